// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Standby Wakeup and Break Generation

This block is a full-duplex serial port for a byte-wide register bus. Every character is sent and received in NRZ form: one low start bit, the data bits least significant first, and one high stop bit. A divider turns the system clock into a 16x oversampling tick. Both the transmitter and the receiver take their bit timing from this tick. The receiver runs its incoming line through a synchronizer. It realigns its bit phase on every falling edge of the line and decides each bit by a two-of-three vote.

Software writes bytes to the data address. It can also queue whole characters of idle line (all ones) or break (all zeros) between them. A single holding register sits in front of the transmit shifter. On receive there is a single data register, with full, overrun and framing-error flags.

A node on a shared line that does not need the current message can put the receiver into standby. In standby the receiver drops every character and raises no flag. It wakes by itself once the line has been idle for ten bit times, so it is ready for the first character of the next message. Three registered interrupt lines report received data or error, transmit register empty, and transmit complete.

Top module: `nrz_uart`

## Requirements
- R1: After reset, txd is 1, irq_rx is 0, irq_tx_empty and irq_tx_done are 1, bus_rdata is 0, and a status read returns 0x18.
- R2: Status bits are: bit 0 receive full, bit 1 framing error, bit 2 overrun, bit 3 transmit holding empty, bit 4 transmit complete, bit 5 standby. A data byte written at address 0 goes out as a low start bit, the eight data bits LSB first, and a high stop bit. Each bit lasts 16 ticks, and one tick comes every baud_div clocks.
- R3: The holding-empty flag returns to 1 once the held entry has moved into the shifter. A data write made while the holding register is full is ignored.
- R4: Writing bit 0 at address 1 queues one character time (10 bit times) of high line. It is sent in order with the data bytes.
- R5: Writing bit 1 at address 1 queues one character time of low line. If bits 0 and 1 are written together, bit 1 wins.
- R6: Transmit complete is 1 exactly when both the shifter and the holding register are empty. While it is signalled, txd is high.
- R7: A received character sets receive full and loads the data register, which is read at address 0. That read clears receive full, overrun and framing error.
- R8: Samples are taken at ticks 7, 8 and 9 of each bit, and the majority decides the bit. If the start bit votes high, the start is rejected and the receiver goes back to hunting.
- R9: The receiver's tick count restarts on every falling edge of the synchronized line. Characters arriving with a bit period 12.5% longer than nominal are received correctly when their data has falling edges every two bits.
- R10: A stop bit that votes low still loads the data register and also sets framing error.
- R11: A character that completes while receive full is set sets overrun and leaves the data register unchanged.
- R12: Writing bit 2 at address 1 enters standby. In standby, received characters are discarded with no flag change. Standby ends after ten consecutive bit times of high line.
- R13: irq_rx equals the OR of the three receive flags, and irq_tx_empty and irq_tx_done follow their status flags, each one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_div | input | 16 | Clocks per oversample tick |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 1 | 0: data, 1: status (read) / command (write) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_rx | output | 1 | Receive data full or error |
| irq_tx_empty | output | 1 | Transmit holding register empty |
| irq_tx_done | output | 1 | Transmission complete |

## Verification
Read data is registered, so a read issued on one clock shows its value on the next edge. Interrupt lines follow their flags one clock later, and the bench samples both on falling clock edges at least one edge after the change. A received character completes at the stop-bit vote. That vote comes about 9.6 bit times plus three synchronizer clocks after the start edge, so the bench reads status only after the whole frame has been driven. For transmission, a behavioural line monitor finds each start edge and samples mid-bit at 16 + 32k clocks (baud_div is 2). It queues each decoded frame with its start cycle and compares the queue to the list of expected characters and their spacing.

// File: rtl/nrz_uart_pkg.sv
package nrz_uart_pkg;
  typedef enum logic [1:0] {
    TXK_DATA  = 2'd0,
    TXK_IDLE  = 2'd1,
    TXK_BREAK = 2'd2
  } tx_kind_e;

  localparam int ST_RXFULL  = 0;
  localparam int ST_FERR    = 1;
  localparam int ST_OVR     = 2;
  localparam int ST_TXEMPTY = 3;
  localparam int ST_TXDONE  = 4;
  localparam int ST_ASLEEP  = 5;

  localparam int CMD_IDLE  = 0;
  localparam int CMD_BREAK = 1;
  localparam int CMD_SLEEP = 2;
endpackage

// File: rtl/nrz_uart_baud.sv
module nrz_uart_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (div <= DIV_W'(1) || cnt >= div - DIV_W'(1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + DIV_W'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/nrz_uart_tx.sv
module nrz_uart_tx
  import nrz_uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_data,
  input  logic              wr_idle,
  input  logic              wr_break,
  input  logic [DATA_W-1:0] wdata,
  output logic              txd,
  output logic              hold_empty,
  output logic              done
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int SUB_W   = $clog2(OVS);
  localparam int BIT_W   = $clog2(FRAME_W);

  logic               hold_v;
  tx_kind_e           hold_k;
  logic [DATA_W-1:0]  hold_d;
  logic               busy;
  logic [FRAME_W-1:0] shreg;
  logic [FRAME_W-1:0] frame;
  logic [SUB_W-1:0]   sub;
  logic [BIT_W-1:0]   bitn;

  always_comb begin
    case (hold_k)
      TXK_IDLE:  frame = '1;
      TXK_BREAK: frame = '0;
      default:   frame = {1'b1, hold_d, 1'b0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v <= 1'b0;
      hold_k <= TXK_DATA;
      hold_d <= '0;
      busy   <= 1'b0;
      shreg  <= '1;
      sub    <= '0;
      bitn   <= '0;
      txd    <= 1'b1;
    end else begin
      if (!busy && hold_v) begin
        busy   <= 1'b1;
        hold_v <= 1'b0;
        sub    <= '0;
        bitn   <= '0;
        shreg  <= frame;
        txd    <= frame[0];
      end else if (busy && tick) begin
        if (sub == SUB_W'(OVS - 1)) begin
          sub <= '0;
          if (bitn == BIT_W'(FRAME_W - 1)) begin
            busy <= 1'b0;
            txd  <= 1'b1;
          end else begin
            bitn  <= bitn + BIT_W'(1);
            shreg <= {1'b1, shreg[FRAME_W-1:1]};
            txd   <= shreg[1];
          end
        end else begin
          sub <= sub + SUB_W'(1);
        end
      end
      if (!hold_v && (wr_data || wr_idle || wr_break)) begin
        hold_v <= 1'b1;
        hold_k <= wr_break ? TXK_BREAK : (wr_idle ? TXK_IDLE : TXK_DATA);
        hold_d <= wdata;
      end
    end
  end

  assign hold_empty = !hold_v;
  assign done       = !busy && !hold_v;
endmodule

// File: rtl/nrz_uart_rx.sv
module nrz_uart_rx #(
  parameter int DATA_W    = 8,
  parameter int OVS       = 16,
  parameter int IDLE_BITS = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd,
  input  logic              sleep_req,
  input  logic              rd_ack,
  output logic [DATA_W-1:0] data,
  output logic              full,
  output logic              ferr,
  output logic              ovr,
  output logic              asleep
);
  localparam int SUB_W      = $clog2(OVS);
  localparam int BIT_W      = $clog2(DATA_W + 2);
  localparam int IDLE_TICKS = IDLE_BITS * OVS;
  localparam int IW         = $clog2(IDLE_TICKS + 1);
  localparam logic [SUB_W-1:0] S_A = SUB_W'(OVS/2 - 1);
  localparam logic [SUB_W-1:0] S_B = SUB_W'(OVS/2);
  localparam logic [SUB_W-1:0] S_C = SUB_W'(OVS/2 + 1);

  logic              s1, s2, s3;
  logic              fall;
  logic              active;
  logic [SUB_W-1:0]  sub;
  logic [BIT_W-1:0]  bitn;
  logic [1:0]        smp;
  logic              vote;
  logic [DATA_W-1:0] shreg;
  logic [IW-1:0]     idle_cnt;

  assign fall = s3 & ~s2;
  assign vote = (smp[0] & smp[1]) | (smp[0] & s2) | (smp[1] & s2);

  always_ff @(posedge clk) begin
    if (rst) begin
      {s1, s2, s3} <= 3'b111;
      active   <= 1'b0;
      sub      <= '0;
      bitn     <= '0;
      smp      <= 2'b11;
      shreg    <= '0;
      data     <= '0;
      full     <= 1'b0;
      ferr     <= 1'b0;
      ovr      <= 1'b0;
      asleep   <= 1'b0;
      idle_cnt <= '0;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      s3 <= s2;
      if (rd_ack) begin
        full <= 1'b0;
        ferr <= 1'b0;
        ovr  <= 1'b0;
      end
      if (fall) begin
        sub <= '0;
        if (!active) begin
          active <= 1'b1;
          bitn   <= '0;
        end
      end else if (active && tick) begin
        sub <= sub + SUB_W'(1);
        if (sub == S_A) smp[0] <= s2;
        if (sub == S_B) smp[1] <= s2;
        if (sub == S_C) begin
          if (bitn == '0) begin
            if (vote) active <= 1'b0;
            else      bitn   <= BIT_W'(1);
          end else if (bitn == BIT_W'(DATA_W + 1)) begin
            active <= 1'b0;
            if (!asleep) begin
              if (full) begin
                ovr <= 1'b1;
              end else begin
                data <= shreg;
                full <= 1'b1;
                ferr <= ~vote;
              end
            end
          end else begin
            shreg <= {vote, shreg[DATA_W-1:1]};
            bitn  <= bitn + BIT_W'(1);
          end
        end
      end
      if (sleep_req) begin
        asleep   <= 1'b1;
        idle_cnt <= '0;
      end else if (!s2) begin
        idle_cnt <= '0;
      end else if (tick && asleep) begin
        if (idle_cnt == IW'(IDLE_TICKS - 1)) begin
          asleep   <= 1'b0;
          idle_cnt <= '0;
        end else begin
          idle_cnt <= idle_cnt + IW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/nrz_uart.sv
module nrz_uart
  import nrz_uart_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DIV_W     = 16,
  parameter int OVS       = 16,
  parameter int IDLE_BITS = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rxd,
  output logic              txd,
  output logic              irq_rx,
  output logic              irq_tx_empty,
  output logic              irq_tx_done
);
  logic              tick;
  logic              wr_data, wr_cmd, rd_ack;
  logic              tx_hold_empty, tx_done;
  logic [DATA_W-1:0] rx_data;
  logic              rx_full, rx_ferr, rx_ovr, rx_asleep;
  logic [DATA_W-1:0] status;

  assign wr_data = bus_sel & bus_wr & ~bus_addr;
  assign wr_cmd  = bus_sel & bus_wr & bus_addr;
  assign rd_ack  = bus_sel & bus_rd & ~bus_addr;

  nrz_uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .div(baud_div), .tick(tick)
  );

  nrz_uart_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .tick(tick),
    .wr_data(wr_data),
    .wr_idle(wr_cmd & bus_wdata[CMD_IDLE]),
    .wr_break(wr_cmd & bus_wdata[CMD_BREAK]),
    .wdata(bus_wdata), .txd(txd),
    .hold_empty(tx_hold_empty), .done(tx_done)
  );

  nrz_uart_rx #(.DATA_W(DATA_W), .OVS(OVS), .IDLE_BITS(IDLE_BITS)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .rxd(rxd),
    .sleep_req(wr_cmd & bus_wdata[CMD_SLEEP]), .rd_ack(rd_ack),
    .data(rx_data), .full(rx_full), .ferr(rx_ferr), .ovr(rx_ovr),
    .asleep(rx_asleep)
  );

  always_comb begin
    status             = '0;
    status[ST_RXFULL]  = rx_full;
    status[ST_FERR]    = rx_ferr;
    status[ST_OVR]     = rx_ovr;
    status[ST_TXEMPTY] = tx_hold_empty;
    status[ST_TXDONE]  = tx_done;
    status[ST_ASLEEP]  = rx_asleep;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata    <= '0;
      irq_rx       <= 1'b0;
      irq_tx_empty <= 1'b0;
      irq_tx_done  <= 1'b0;
    end else begin
      if (bus_sel && bus_rd) bus_rdata <= bus_addr ? status : rx_data;
      irq_rx       <= rx_full | rx_ferr | rx_ovr;
      irq_tx_empty <= tx_hold_empty;
      irq_tx_done  <= tx_done;
    end
  end
endmodule

// File: rtl/nrz_uart_chk.sv
module nrz_uart_chk (
  input logic clk,
  input logic rst,
  input logic txd,
  input logic irq_tx_done,
  input logic rx_full,
  input logic rx_ferr,
  input logic rx_ovr,
  input logic rx_asleep
);
  // R6
  txd_high_when_done_chk: assert property (@(posedge clk) disable iff (rst)
    irq_tx_done |-> txd);

  // R10
  ferr_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
    rx_ferr |-> rx_full);

  // R11
  ovr_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
    rx_ovr |-> rx_full);

  // R12
  no_rx_in_standby_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_asleep && $past(rx_asleep)) |-> !$rose(rx_full));
endmodule

bind nrz_uart nrz_uart_chk u_chk (
  .clk(clk), .rst(rst), .txd(txd), .irq_tx_done(irq_tx_done),
  .rx_full(rx_full), .rx_ferr(rx_ferr), .rx_ovr(rx_ovr),
  .rx_asleep(rx_asleep)
);

// File: tb/nrz_uart_tb.sv
module nrz_uart_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        rxd_drv = 1'b1;
  logic        txd, irq_rx, irq_tx_empty, irq_tx_done;
  int          checks = 0, errors = 0, cyc = 0;
  logic [9:0]  mon_q[$];
  int          mon_t[$];
  logic [7:0]  rv;
  bit          finished = 0;

  always #2.5ns clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nrz_uart u_dut (
    .clk(clk), .rst(rst), .baud_div(16'd2),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd(rxd_drv), .txd(txd),
    .irq_rx(irq_rx), .irq_tx_empty(irq_tx_empty), .irq_tx_done(irq_tx_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 0; bus_rd = 0;
  endtask

  task automatic send_bits(input logic [9:0] bits, input int bclk);
    for (int i = 0; i < 10; i++) begin
      rxd_drv = bits[i];
      repeat (bclk) @(negedge clk);
    end
  endtask

  task automatic wait_done();
    repeat (4) @(negedge clk);
    for (int i = 0; i < 2000 && !irq_tx_done; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // Line monitor: decodes every transmitted character at mid-bit
  initial begin
    forever begin
      logic [9:0] b;
      @(negedge txd);
      mon_t.push_back(cyc);
      repeat (16) @(negedge clk);
      b[0] = txd;
      for (int i = 1; i < 10; i++) begin
        repeat (32) @(negedge clk);
        b[i] = txd;
      end
      mon_q.push_back(b);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", bus_rdata, 0);
    rst = 0;
    repeat (4) @(negedge clk);
    chk("R1 txd", txd, 1);
    chk("R1 irq_rx", irq_rx, 0);
    chk("R1 irq_tx_empty", irq_tx_empty, 1);
    chk("R1 irq_tx_done", irq_tx_done, 1);
    bus_read(1, rv);
    chk("R1 status", rv, 8'h18);

    // R2 plain byte, R3 empty flag after move to shifter
    bus_write(0, 8'hA5);
    repeat (2) @(negedge clk);
    bus_read(1, rv);
    chk("R3 tx_empty after move", rv[3], 1);
    chk("R6 tx_done while sending", rv[4], 0);
    wait_done();
    chk("R2 frame count", mon_q.size(), 1);
    if (mon_q.size() > 0) chk("R2 frame bits", mon_q.pop_front(), {1'b1, 8'hA5, 1'b0});
    mon_t.delete();
    chk("R6 irq_tx_done", irq_tx_done, 1);
    chk("R13 irq_tx_empty", irq_tx_empty, 1);

    // R3 write while holding full is ignored
    bus_write(0, 8'hA1);
    repeat (3) @(negedge clk);
    bus_write(0, 8'hB2);
    bus_write(0, 8'hC3);
    bus_read(1, rv);
    chk("R3 holding full", rv[3], 0);
    wait_done();
    chk("R3 frame count", mon_q.size(), 2);
    if (mon_q.size() > 1) begin
      chk("R3 first", mon_q.pop_front(), {1'b1, 8'hA1, 1'b0});
      chk("R3 second", mon_q.pop_front(), {1'b1, 8'hB2, 1'b0});
    end
    mon_q.delete(); mon_t.delete();

    // R5 break, both command bits given
    bus_write(1, 8'h03);
    wait_done();
    chk("R5 break count", mon_q.size(), 1);
    if (mon_q.size() > 0) chk("R5 break bits", mon_q.pop_front(), 0);
    mon_t.delete();

    // R4 idle character between two bytes
    bus_write(0, 8'h11);
    repeat (4) @(negedge clk);
    bus_write(1, 8'h01);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2000 && !irq_tx_empty; i++) @(negedge clk);
    bus_write(0, 8'h22);
    wait_done();
    chk("R4 frame count", mon_q.size(), 2);
    if (mon_q.size() > 1 && mon_t.size() > 1) begin
      chk("R4 first", mon_q.pop_front(), {1'b1, 8'h11, 1'b0});
      chk("R4 second", mon_q.pop_front(), {1'b1, 8'h22, 1'b0});
      chk("R4 idle gap", (mon_t[1] - mon_t[0] >= 630 && mon_t[1] - mon_t[0] <= 650), 1);
    end
    mon_q.delete(); mon_t.delete();

    // R7 reception and read clear
    repeat (40) @(negedge clk);
    send_bits({1'b1, 8'h3C, 1'b0}, 32);
    repeat (4) @(negedge clk);
    bus_read(1, rv);
    chk("R7 status full", rv[2:0], 3'b001);
    chk("R13 irq_rx set", irq_rx, 1);
    bus_read(0, rv);
    chk("R7 data", rv, 8'h3C);
    repeat (2) @(negedge clk);
    bus_read(1, rv);
    chk("R7 cleared", rv[2:0], 0);
    chk("R13 irq_rx clear", irq_rx, 0);

    // R11 overrun
    send_bits({1'b1, 8'h5A, 1'b0}, 32);
    send_bits({1'b1, 8'h96, 1'b0}, 32);
    repeat (4) @(negedge clk);
    bus_read(1, rv);
    chk("R11 status", rv[2:0], 3'b101);
    bus_read(0, rv);
    chk("R11 data kept", rv, 8'h5A);

    // R10 framing error
    send_bits({1'b0, 8'h7E, 1'b0}, 32);
    rxd_drv = 1;
    repeat (40) @(negedge clk);
    bus_read(1, rv);
    chk("R10 status", rv[2:0], 3'b011);
    bus_read(0, rv);
    chk("R10 data", rv, 8'h7E);

    // R8 short low pulse rejected, then normal byte
    rxd_drv = 0;
    repeat (6) @(negedge clk);
    rxd_drv = 1;
    repeat (400) @(negedge clk);
    bus_read(1, rv);
    chk("R8 glitch rejected", rv[0], 0);
    send_bits({1'b1, 8'h81, 1'b0}, 32);
    repeat (4) @(negedge clk);
    bus_read(0, rv);
    chk("R8 next byte", rv, 8'h81);

    // R9 slow sender, realigned on falling edges
    repeat (40) @(negedge clk);
    send_bits({1'b1, 8'h55, 1'b0}, 36);
    repeat (4) @(negedge clk);
    bus_read(1, rv);
    chk("R9 status", rv[2:0], 3'b001);
    bus_read(0, rv);
    chk("R9 data", rv, 8'h55);

    // R12 standby discards until ten idle bit times
    repeat (40) @(negedge clk);
    bus_write(1, 8'h04);
    send_bits({1'b1, 8'h44, 1'b0}, 32);
    send_bits({1'b1, 8'h45, 1'b0}, 32);
    repeat (4) @(negedge clk);
    bus_read(1, rv);
    chk("R12 discarded", rv[2:0], 0);
    chk("R12 still asleep", rv[5], 1);
    repeat (400) @(negedge clk);
    bus_read(1, rv);
    chk("R12 woke", rv[5], 0);
    send_bits({1'b1, 8'h66, 1'b0}, 32);
    repeat (4) @(negedge clk);
    bus_read(0, rv);
    chk("R12 next message", rv, 8'h66);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule